// File: doc/BRIEF.md
# Reset and Fail-Safe Mode Controller

This block gathers every reset source of a small microcontroller into one synchronized internal reset and decides, from a strap pin, whether software may enter the power-saving modes. Reset sources are an active-low external reset pin, a one-clock watchdog overflow pulse and a one-clock oscillator-failure pulse. The external pin is filtered: it only counts once it has stayed low across a whole machine cycle, measured with a machine-cycle strobe supplied by the clock generator. The oscillator-failure source can be switched off by its own enable strap.

Every source crosses a two-flop synchronizer. Once the last source has gone away, the internal reset is stretched by a programmable number of machine cycles and released on a strobe. The two straps are captured on that releasing clock and kept until the next reset. The captured mode-lock strap tells the watchdog to start on its own. Separately, the live level of the same strap blocks software requests for power-down, idle and slow-down, and the block grants at most one such mode at a time.

Top module: `failsafe_reset_ctrl`

## Requirements
- R1: The external pin raises a reset only when its synchronized level is low at two successive machine-cycle strobes, 12 clocks apart. A low pulse of 12 clocks or less never causes a reset. A low pulse of 25 clocks or more always causes one, and the reset is seen within 6 clocks after the pin returns high.
- R2: A one-clock watchdog overflow pulse drives rst_out_n low within 4 clocks.
- R3: A one-clock oscillator-failure pulse resets the block within 4 clocks when the oscillator-monitor strap was captured high at the last reset release. When that strap was captured low, the pulse is ignored and rst_out_n stays high.
- R4: The internal reset falls only on a clock that follows a strobe. This happens no sooner than HOLD_MC machine cycles (24 clocks at default) after the last source is removed, and no later than 44 clocks after it.
- R5: rst_out_n is always the inverse of int_rst.
- R6: wdt_autostart is 0 during reset. After reset it equals the mode-lock strap level captured on the releasing clock, and later changes of the strap do not alter it.
- R7: A request produces its grant one clock later, only while the synchronized live mode-lock strap is low and no reset is active. While the strap is high, or during reset, all grants are 0.
- R8: When several requests are present, at most one grant is high. Power-down wins over idle, and idle wins over slow-down.
- R9: While por_n is low, and on the clock after it rises, int_rst is 1, rst_out_n is 0, and all grants and wdt_autostart are 0. The reset then releases as described in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-derived clock |
| por_n | input | 1 | Power-on reset of the block itself, synchronous, active low |
| mc_stb | input | 1 | One-clock strobe, once per machine cycle |
| ext_rst_n | input | 1 | External reset pin, asynchronous, active low |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| osc_fail | input | 1 | Oscillator monitor failure pulse |
| strap_lock | input | 1 | Mode-lock / watchdog auto-start strap, high = locked |
| strap_oscmon | input | 1 | Oscillator monitor enable strap, high = enabled |
| req_idle | input | 1 | Software request for idle mode |
| req_pdown | input | 1 | Software request for power-down mode |
| req_slow | input | 1 | Software request for slow-down mode |
| int_rst | output | 1 | Synchronized internal reset, active high |
| rst_out_n | output | 1 | Reset output pin, active low |
| wdt_autostart | output | 1 | Watchdog should start by itself |
| grant_idle | output | 1 | Idle mode granted |
| grant_pdown | output | 1 | Power-down mode granted |
| grant_slow | output | 1 | Slow-down mode granted |

## Verification
A corrupted pin-qualifier state shows up as a reset after a short glitch, or as a missing reset after a long low pulse, within about two machine cycles. A wrong stretch counter moves the rising edge of rst_out_n outside the 24 to 44 clock window, so it is visible one release later. A strap latch that is captured at the wrong time is exposed by wdt_autostart, and by whether a following oscillator-failure pulse resets the block. A wrong grant encoding appears on the grant pins one clock after the request.

// File: rtl/rfs_pkg.sv
`timescale 1ns/1ps
// Shared types for the reset and fail-safe controller.
// Assumes: consumers import the package before use.
package rfs_pkg;
    // Power-saving mode that is currently granted, at most one.
    typedef enum logic [1:0] {
        PM_NONE  = 2'd0,
        PM_SLOW  = 2'd1,
        PM_IDLE  = 2'd2,
        PM_PDOWN = 2'd3
    } pmode_e;

    // Default number of machine cycles the reset is stretched.
    localparam int DEF_HOLD_MC = 2;
endpackage

// File: rtl/rfs_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer for a vector of independent asynchronous bits.
// Assumes: every bit is a level or a pulse lasting at least one clock;
// RST_VAL is the inactive level each bit takes under reset.
module rfs_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;
    logic [W-1:0] stab;

    // Capture and re-time every input bit through two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            stab <= RST_VAL;
        end else begin
            meta <= d;
            stab <= meta;
        end
    end

    assign q = stab;
endmodule

// File: rtl/rfs_pin_qual.sv
`timescale 1ns/1ps
// Qualifies the synchronized external reset pin: it is accepted only when
// low at two successive machine-cycle strobes, and is dropped at once when
// the pin returns high.
// Assumes: pin_low is already synchronized; mc_stb is one clock wide.
module rfs_pin_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic mc_stb,
    input  logic pin_low,
    output logic ext_act
);
    logic armed;

    // Arm on the first strobe seen low, qualify on the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed   <= 1'b0;
            ext_act <= 1'b0;
        end else if (!pin_low) begin
            armed   <= 1'b0;
            ext_act <= 1'b0;
        end else if (mc_stb) begin
            armed <= 1'b1;
            if (armed) ext_act <= 1'b1;
        end
    end

    // R1
    ext_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_act) |-> ($past(mc_stb) && $past(armed)));

    // R1
    ext_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_low |=> !ext_act);
endmodule

// File: rtl/rfs_stretch.sv
`timescale 1ns/1ps
// Merges qualified reset sources, stretches the internal reset by HOLD_MC
// machine cycles after the last one goes away, releases it on a strobe and
// captures the two straps on that releasing clock.
// Assumes: all inputs synchronous to clk; mc_stb is one clock wide.
module rfs_stretch #(
    parameter int HOLD_MC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mc_stb,
    input  logic ext_act,
    input  logic wdt_hit,
    input  logic osc_hit,
    input  logic lock_s,
    input  logic oscmon_s,
    output logic rst_q,
    output logic lock_lat,
    output logic oscmon_lat
);
    localparam int CW = $clog2(HOLD_MC + 1) + 1;

    logic          src;
    logic [CW-1:0] cnt;

    // Any active source; oscillator failure only counts when enabled.
    always_comb src = ext_act | wdt_hit | (osc_hit & oscmon_lat);

    // Hold, count strobes after release and capture straps on the last clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_q      <= 1'b1;
            cnt        <= '0;
            lock_lat   <= 1'b1;
            oscmon_lat <= 1'b1;
        end else if (src) begin
            rst_q <= 1'b1;
            cnt   <= '0;
        end else if (rst_q && mc_stb) begin
            if (cnt == CW'(HOLD_MC)) begin
                rst_q      <= 1'b0;
                lock_lat   <= lock_s;
                oscmon_lat <= oscmon_s;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R4
    release_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_q) |-> $past(mc_stb));

    // R2
    source_holds_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_act || wdt_hit) |=> rst_q);

    // R3
    osc_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_q && !oscmon_lat && !ext_act && !wdt_hit) |=> !rst_q);

    // R6
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_q && $past(rst_q)) |-> ($stable(lock_lat) && $stable(oscmon_lat)));
endmodule

// File: rtl/rfs_mode_gate.sv
`timescale 1ns/1ps
// Grants at most one power-saving mode per clock, power-down first, then
// idle, then slow-down, and only when unlocked and out of reset.
// Assumes: block_modes is the synchronized live mode-lock strap.
module rfs_mode_gate
    import rfs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic int_rst,
    input  logic block_modes,
    input  logic req_idle,
    input  logic req_pdown,
    input  logic req_slow,
    output logic grant_idle,
    output logic grant_pdown,
    output logic grant_slow
);
    pmode_e pick;
    pmode_e cur;

    // Choose the winning request, or none when locked or in reset.
    always_comb begin
        pick = PM_NONE;
        if (!block_modes && !int_rst) begin
            if (req_pdown)      pick = PM_PDOWN;
            else if (req_idle)  pick = PM_IDLE;
            else if (req_slow)  pick = PM_SLOW;
        end
    end

    // Register the chosen mode.
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= PM_NONE;
        else        cur <= pick;
    end

    assign grant_pdown = (cur == PM_PDOWN);
    assign grant_idle  = (cur == PM_IDLE);
    assign grant_slow  = (cur == PM_SLOW);

    // R8
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant_pdown, grant_idle, grant_slow}));

    // R7
    locked_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (block_modes || int_rst) |=> !(grant_pdown || grant_idle || grant_slow));

    // R8
    pdown_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_pdown && !block_modes && !int_rst) |=> grant_pdown);
endmodule

// File: rtl/failsafe_reset_ctrl.sv
`timescale 1ns/1ps
// Reset and fail-safe mode controller: synchronizes the reset sources and
// straps, filters the external pin, stretches the internal reset, captures
// the straps at release and gates the power-saving mode requests.
// Assumes: mc_stb pulses one clock per machine cycle; por_n is synchronous.
module failsafe_reset_ctrl #(
    parameter int HOLD_MC = rfs_pkg::DEF_HOLD_MC
) (
    input  logic clk,
    input  logic por_n,
    input  logic mc_stb,
    input  logic ext_rst_n,
    input  logic wdt_ovf,
    input  logic osc_fail,
    input  logic strap_lock,
    input  logic strap_oscmon,
    input  logic req_idle,
    input  logic req_pdown,
    input  logic req_slow,
    output logic int_rst,
    output logic rst_out_n,
    output logic wdt_autostart,
    output logic grant_idle,
    output logic grant_pdown,
    output logic grant_slow
);
    logic [2:0] lvl_s;
    logic [1:0] evt_s;
    logic       ext_act;
    logic       rst_q;
    logic       lock_lat;
    logic       oscmon_lat;

    // Levels that idle high: pin, mode-lock strap, oscillator-monitor strap.
    rfs_sync #(.W(3), .RST_VAL(3'b111)) u_sync_lvl (
        .clk   (clk),
        .rst_n (por_n),
        .d     ({ext_rst_n, strap_lock, strap_oscmon}),
        .q     (lvl_s)
    );

    // Events that idle low: watchdog overflow, oscillator failure.
    rfs_sync #(.W(2), .RST_VAL(2'b00)) u_sync_evt (
        .clk   (clk),
        .rst_n (por_n),
        .d     ({wdt_ovf, osc_fail}),
        .q     (evt_s)
    );

    rfs_pin_qual u_qual (
        .clk     (clk),
        .rst_n   (por_n),
        .mc_stb  (mc_stb),
        .pin_low (!lvl_s[2]),
        .ext_act (ext_act)
    );

    rfs_stretch #(.HOLD_MC(HOLD_MC)) u_stretch (
        .clk        (clk),
        .rst_n      (por_n),
        .mc_stb     (mc_stb),
        .ext_act    (ext_act),
        .wdt_hit    (evt_s[1]),
        .osc_hit    (evt_s[0]),
        .lock_s     (lvl_s[1]),
        .oscmon_s   (lvl_s[0]),
        .rst_q      (rst_q),
        .lock_lat   (lock_lat),
        .oscmon_lat (oscmon_lat)
    );

    rfs_mode_gate u_gate (
        .clk         (clk),
        .rst_n       (por_n),
        .int_rst     (rst_q),
        .block_modes (lvl_s[1]),
        .req_idle    (req_idle),
        .req_pdown   (req_pdown),
        .req_slow    (req_slow),
        .grant_idle  (grant_idle),
        .grant_pdown (grant_pdown),
        .grant_slow  (grant_slow)
    );

    assign int_rst       = rst_q;
    assign rst_out_n     = ~rst_q;
    assign wdt_autostart = lock_lat & ~rst_q;

    // R5
    pin_mirror_chk: assert property (@(posedge clk) disable iff (!por_n)
        rst_out_n != int_rst);

    // R6
    autostart_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
        int_rst |-> !wdt_autostart);
endmodule

// File: tb/sim_failsafe_reset_ctrl.sv
`timescale 1ns/1ps
module sim_failsafe_reset_ctrl;
    logic clk = 1'b0;
    logic por_n, mc_stb, ext_rst_n, wdt_ovf, osc_fail;
    logic strap_lock, strap_oscmon, req_idle, req_pdown, req_slow;
    logic int_rst, rst_out_n, wdt_autostart, grant_idle, grant_pdown, grant_slow;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    failsafe_reset_ctrl u0 (
        .clk(clk), .por_n(por_n), .mc_stb(mc_stb), .ext_rst_n(ext_rst_n),
        .wdt_ovf(wdt_ovf), .osc_fail(osc_fail), .strap_lock(strap_lock),
        .strap_oscmon(strap_oscmon), .req_idle(req_idle), .req_pdown(req_pdown),
        .req_slow(req_slow), .int_rst(int_rst), .rst_out_n(rst_out_n),
        .wdt_autostart(wdt_autostart), .grant_idle(grant_idle),
        .grant_pdown(grant_pdown), .grant_slow(grant_slow)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_grant(bit blk, bit rst, bit pd, bit id, bit sl);
        if (blk || rst) return 3'b000;
        if (pd) return 3'b100;
        if (id) return 3'b010;
        if (sl) return 3'b001;
        return 3'b000;
    endfunction

    // Machine-cycle strobe: one clock high every twelve.
    initial begin
        mc_stb = 1'b0;
        forever begin
            repeat (11) @(negedge clk);
            mc_stb = 1'b1;
            @(negedge clk);
            mc_stb = 1'b0;
        end
    end

    // R5 checked at every sample point.
    initial begin
        forever begin
            @(negedge clk);
            if (por_n === 1'b1)
                chk(rst_out_n == !int_rst, "R5", "rst_out_n mirror", rst_out_n, !int_rst);
        end
    end

    // Wait until reset releases; returns clocks waited.
    task automatic wait_release(output int n);
        n = 0;
        while (rst_out_n !== 1'b1 && n < 400) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic pulse(input bit is_wdt);
        if (is_wdt) wdt_ovf = 1'b1; else osc_fail = 1'b1;
        @(negedge clk);
        wdt_ovf  = 1'b0;
        osc_fail = 1'b0;
    endtask

    // Returns clocks from pulse start until rst_out_n low (cap 40).
    task automatic pulse_and_watch(input bit is_wdt, output int lat);
        int t0;
        t0 = cyc;
        pulse(is_wdt);
        lat = 1;
        while (rst_out_n === 1'b1 && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic wdt_reset_cycle(output int rel);
        int lat;
        int n;
        pulse_and_watch(1'b1, lat);
        wait_release(n);
        rel = lat + n;
    endtask

    initial begin
        int n, lat, rel, w;
        bit seen;
        logic [2:0] g, e;
        bit pd, id, sl;
        void'($urandom(32'h5eed_0017));
        por_n = 0; ext_rst_n = 1; wdt_ovf = 0; osc_fail = 0;
        strap_lock = 1; strap_oscmon = 1; req_idle = 0; req_pdown = 0; req_slow = 0;
        repeat (5) @(negedge clk);
        // R9 reset state
        chk(int_rst == 1 && rst_out_n == 0, "R9", "reset during por", rst_out_n, 0);
        chk({grant_pdown, grant_idle, grant_slow, wdt_autostart} == 4'b0, "R9",
            "grants/autostart in por", {grant_pdown, grant_idle, grant_slow, wdt_autostart}, 0);
        por_n = 1;
        @(negedge clk);
        chk(int_rst == 1, "R9", "reset after por", int_rst, 1);
        wait_release(n);
        chk(n + 1 >= 24 && n + 1 <= 44, "R4", "por release clocks", n + 1, 30);
        // R6: lock strap high captured
        chk(wdt_autostart == 1, "R6", "autostart lock high", wdt_autostart, 1);

        // R7: locked strap blocks requests
        req_idle = 1;
        repeat (2) @(negedge clk);
        chk(grant_idle == 0, "R7", "idle blocked while locked", grant_idle, 0);
        req_idle = 0;

        // Unlock live strap; latched autostart must not change
        strap_lock = 0;
        repeat (4) @(negedge clk);
        chk(wdt_autostart == 1, "R6", "autostart keeps captured value", wdt_autostart, 1);

        // Directed priority case, R8
        req_pdown = 1; req_idle = 1; req_slow = 1;
        @(negedge clk);
        chk({grant_pdown, grant_idle, grant_slow} == 3'b100, "R8", "all requests",
            {grant_pdown, grant_idle, grant_slow}, 3'b100);
        req_pdown = 0;
        @(negedge clk);
        chk({grant_pdown, grant_idle, grant_slow} == 3'b010, "R8", "idle over slow",
            {grant_pdown, grant_idle, grant_slow}, 3'b010);

        // Random requests, unlocked then locked, R7 and R8
        for (int k = 0; k < 120; k++) begin
            if (k == 80) begin
                strap_lock = 1;
                req_pdown = 0; req_idle = 0; req_slow = 0;
                repeat (4) @(negedge clk);
            end
            pd = $urandom_range(0, 1); id = $urandom_range(0, 1); sl = $urandom_range(0, 1);
            req_pdown = pd; req_idle = id; req_slow = sl;
            @(negedge clk);
            g = {grant_pdown, grant_idle, grant_slow};
            e = exp_grant(k >= 80, 1'b0, pd, id, sl);
            chk(g == e, (k >= 80) ? "R7" : "R8", "random grant", g, e);
        end
        strap_lock = 0;
        req_pdown = 0; req_idle = 1; req_slow = 0;
        repeat (4) @(negedge clk);

        // R2: watchdog pulse, grants dropped in reset, release window
        pulse_and_watch(1'b1, lat);
        chk(lat <= 4, "R2", "wdt reset latency", lat, 3);
        @(negedge clk);
        chk(grant_idle == 0 && wdt_autostart == 0, "R7", "no grant/autostart in reset",
            {grant_idle, wdt_autostart}, 0);
        wait_release(n);
        chk(lat + n >= 24 && lat + n <= 44, "R4", "wdt release window", lat + n, 30);
        chk(wdt_autostart == 0, "R6", "autostart lock low", wdt_autostart, 0);
        @(negedge clk);
        chk(grant_idle == 1, "R7", "grant after reset", grant_idle, 1);
        req_idle = 0;

        // R1: short pulses ignored
        for (int k = 0; k < 6; k++) begin
            w = $urandom_range(1, 12);
            seen = 0;
            ext_rst_n = 0;
            repeat (w) begin @(negedge clk); if (!rst_out_n) seen = 1; end
            ext_rst_n = 1;
            repeat (40) begin @(negedge clk); if (!rst_out_n) seen = 1; end
            chk(!seen, "R1", "short ext pulse ignored", seen, 0);
        end
        // R1: long pulses recognized, R4 release after pin high
        for (int k = 0; k < 6; k++) begin
            w = $urandom_range(25, 40);
            seen = 0;
            ext_rst_n = 0;
            repeat (w) begin @(negedge clk); if (!rst_out_n) seen = 1; end
            ext_rst_n = 1;
            n = 0;
            repeat (6) begin @(negedge clk); n++; if (!rst_out_n) seen = 1; end
            chk(seen, "R1", "long ext pulse resets", seen, 1);
            wait_release(lat);
            chk(n + lat >= 24 && n + lat <= 44, "R4", "ext release window", n + lat, 30);
            repeat (5) @(negedge clk);
        end

        // R3: oscillator monitor disabled at capture -> ignored
        strap_oscmon = 0;
        repeat (4) @(negedge clk);
        wdt_reset_cycle(rel);
        pulse_and_watch(1'b0, lat);
        chk(lat >= 40, "R3", "osc fail masked", lat, 40);
        // enabled at capture -> reset
        strap_oscmon = 1;
        repeat (4) @(negedge clk);
        wdt_reset_cycle(rel);
        pulse_and_watch(1'b0, lat);
        chk(lat <= 4, "R3", "osc fail resets", lat, 3);
        wait_release(n);
        chk(lat + n >= 24 && lat + n <= 44, "R4", "osc release window", lat + n, 30);

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Watchdog for a hung run.
    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule